// File: doc/BRIEF.md
# Calendar-Sequenced FIFO Status Receiver

This block receives per-channel FIFO fill status from the far end of a link. Status words carry no channel number. Each word's channel is inferred from its position in a cycle. That position is resolved through a programmable calendar table, which lists channel numbers and may repeat a channel so that faster channels report more often. A cycle opens with a framing word (binary 11). The next `len + 1` two-bit words are slot words, and slot k belongs to the channel held in calendar entry k. A two-bit parity word closes the cycle.

Each slot word is written into a status memory at its channel's address. User logic reads that memory through an independent read port. The parity word tells the block whether the cycle was clean. Channels written during a damaged cycle are tagged as suspect until a clean cycle rewrites them. A link-synchronized flag follows runs of good and bad cycles. The calendar can be loaded from the same programming bus as a matching transmit-side calendar.

Top module: `fifo_stat_rx`

## Requirements
- R1: A write with `cal_we` stores `cal_chan` into calendar entry `cal_addr`. A write with `len_we` stores `len_val`, which is the number of slots per cycle minus one.
- R2: A framing word 2'b11 received while hunting starts a cycle. Slot word k of that cycle is written into the status of the channel named by calendar entry k.
- R3: When a channel appears several times in the calendar, its stored status after the cycle equals the slot word of its last occurrence.
- R4: The word after the last slot is parity. The expected value is the bitwise inverse of the XOR of all slot words in the cycle. On a mismatch `dip_err` is high for exactly one cycle, in the cycle after the parity word is sampled.
- R5: `rd_data[2]` is a suspect bit. It is set for every channel written in a cycle that ends in a parity mismatch or is cut short by a framing word. A later cycle that rewrites the channel and ends in a parity match clears it.
- R6: A word 2'b11 received in a slot position is not stored. It aborts the cycle, and the next word is taken as slot 0.
- R7: `rd_data` returns {suspect, status[1:0]} of channel `rd_addr`, one clock after `rd_addr` is presented.
- R8: `link_sync` rises after GOOD_N (default 2) consecutive good cycles. It falls after BAD_N (default 2) consecutive bad cycles. A parity mismatch and an aborted cycle each count as bad.
- R9: After reset, every channel reads 3'b000, `link_sync` is 0, `dip_err` is 0, and the block is hunting for a framing word.
- R10: While hunting, any word other than 2'b11 is ignored and changes no stored status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_we | input | 1 | Calendar entry write strobe |
| cal_addr | input | CA_W | Calendar entry index |
| cal_chan | input | CH_W | Channel number to store |
| len_we | input | 1 | Length register write strobe |
| len_val | input | CA_W | Slots per cycle minus one |
| stat_word | input | 2 | Incoming status/framing/parity word, one per clock |
| rd_addr | input | CH_W | User read channel |
| rd_data | output | 3 | {suspect, status} of the read channel |
| dip_err | output | 1 | Parity mismatch pulse |
| link_sync | output | 1 | Status link synchronized |

## Verification
The assertions assume that the calendar and the length register are written only while the block is hunting. This keeps the slot index within the programmed length. The bench writes both only between cycles, while the idle word 2'b00 is driven. It presents one read address per clock, so each scoreboard entry is matched to exactly one registered read.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   typedef enum logic [1:0] {ST_HUNT, ST_SLOT, ST_DIP} rx_state_e;
   localparam logic [1:0] FRAME_WORD = 2'b11;

   function automatic logic [1:0] dip2_expect(input logic [1:0] acc);
      return ~acc;
   endfunction
endpackage

// File: rtl/fsr_cal_table.sv
module fsr_cal_table #(
   parameter int NCH       = 8,
   parameter int CAL_DEPTH = 16,
   localparam int CH_W     = $clog2(NCH),
   localparam int CA_W     = $clog2(CAL_DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [CA_W-1:0] waddr,
   input  logic [CH_W-1:0] wchan,
   input  logic            len_we,
   input  logic [CA_W-1:0] len_wdata,
   input  logic [CA_W-1:0] raddr,
   output logic [CH_W-1:0] rchan,
   output logic [CA_W-1:0] len
);
   logic [CH_W-1:0] entry [CAL_DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < CAL_DEPTH; i++) entry[i] <= '0;
         len <= '0;
      end else begin
         if (we)     entry[waddr] <= wchan;
         if (len_we) len <= len_wdata;
      end
   end

   assign rchan = entry[raddr];

   AST_CAL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> entry[$past(waddr)] == $past(wchan)); // R1
endmodule

// File: rtl/fsr_stat_mem.sv
module fsr_stat_mem #(
   parameter int NCH    = 8,
   parameter bit RD_REG = 1'b1,
   localparam int CH_W  = $clog2(NCH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [CH_W-1:0] waddr,
   input  logic [1:0]      wdata,
   input  logic [NCH-1:0]  sus_set,
   input  logic [NCH-1:0]  sus_clr,
   input  logic [CH_W-1:0] rd_addr,
   output logic [2:0]      rd_data
);
   logic [1:0]     st [NCH];
   logic [NCH-1:0] sus;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) st[i] <= '0;
         sus <= '0;
      end else begin
         if (we) st[waddr] <= wdata;
         sus <= (sus | sus_set) & ~sus_clr;
      end
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (!rst_n) rd_data <= '0;
            else        rd_data <= {sus[rd_addr], st[rd_addr]};
         end
      end else begin : g_rd_comb
         assign rd_data = {sus[rd_addr], st[rd_addr]};
      end
   endgenerate

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> st[$past(waddr)] == $past(wdata)); // R2
   AST_SUSPECT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sus_clr != '0) |=> ((sus & $past(sus_clr)) == '0)); // R5
endmodule

// File: rtl/fsr_sync_mon.sv
module fsr_sync_mon #(
   parameter int GOOD_N = 2,
   parameter int BAD_N  = 2,
   localparam int CW    = $clog2((GOOD_N > BAD_N ? GOOD_N : BAD_N) + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic good_evt,
   input  logic bad_evt,
   output logic sync
);
   logic [CW-1:0] good_cnt, bad_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync     <= 1'b0;
         good_cnt <= '0;
         bad_cnt  <= '0;
      end else if (!sync) begin
         bad_cnt <= '0;
         if (bad_evt) good_cnt <= '0;
         else if (good_evt) begin
            if (good_cnt == CW'(GOOD_N - 1)) begin
               sync     <= 1'b1;
               good_cnt <= '0;
            end else good_cnt <= good_cnt + 1'b1;
         end
      end else begin
         good_cnt <= '0;
         if (good_evt) bad_cnt <= '0;
         else if (bad_evt) begin
            if (bad_cnt == CW'(BAD_N - 1)) begin
               sync    <= 1'b0;
               bad_cnt <= '0;
            end else bad_cnt <= bad_cnt + 1'b1;
         end
      end
   end

   AST_SYNC_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync) |-> $past(good_evt)); // R8
   AST_SYNC_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync) |-> $past(bad_evt)); // R8
endmodule

// File: rtl/fifo_stat_rx.sv
module fifo_stat_rx #(
   parameter int NCH       = 8,
   parameter int CAL_DEPTH = 16,
   parameter int GOOD_N    = 2,
   parameter int BAD_N     = 2,
   parameter bit RD_REG    = 1'b1,
   localparam int CH_W     = $clog2(NCH),
   localparam int CA_W     = $clog2(CAL_DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cal_we,
   input  logic [CA_W-1:0] cal_addr,
   input  logic [CH_W-1:0] cal_chan,
   input  logic            len_we,
   input  logic [CA_W-1:0] len_val,
   input  logic [1:0]      stat_word,
   input  logic [CH_W-1:0] rd_addr,
   output logic [2:0]      rd_data,
   output logic            dip_err,
   output logic            link_sync
);
   import fsr_pkg::*;

   generate
      if (NCH < 2 || (1 << CH_W) != NCH) begin : g_bad_nch
         $error("NCH must be a power of two, at least 2");
      end
      if (CAL_DEPTH < 2 || (1 << CA_W) != CAL_DEPTH) begin : g_bad_depth
         $error("CAL_DEPTH must be a power of two, at least 2");
      end
      if (GOOD_N < 1 || BAD_N < 1) begin : g_bad_thr
         $error("GOOD_N and BAD_N must be at least 1");
      end
   endgenerate

   rx_state_e       state;
   logic [CA_W-1:0] slot;
   logic [1:0]      acc;
   logic [NCH-1:0]  mask;
   logic [CH_W-1:0] slot_chan;
   logic [CA_W-1:0] cal_len;
   logic [NCH-1:0]  chan_hot;
   logic            is_frame, wr_en, abort, dip_good, dip_bad;
   logic [NCH-1:0]  sus_set, sus_clr;

   fsr_cal_table #(.NCH(NCH), .CAL_DEPTH(CAL_DEPTH)) u_cal (
      .clk(clk), .rst_n(rst_n), .we(cal_we), .waddr(cal_addr), .wchan(cal_chan),
      .len_we(len_we), .len_wdata(len_val), .raddr(slot), .rchan(slot_chan),
      .len(cal_len));

   always_comb begin
      chan_hot            = '0;
      chan_hot[slot_chan] = 1'b1;
   end

   assign is_frame = (stat_word == FRAME_WORD);
   assign wr_en    = (state == ST_SLOT) && !is_frame;
   assign abort    = (state == ST_SLOT) && is_frame;
   assign dip_good = (state == ST_DIP) && (stat_word == dip2_expect(acc));
   assign dip_bad  = (state == ST_DIP) && (stat_word != dip2_expect(acc));
   assign sus_set  = (abort || dip_bad) ? mask : '0;
   assign sus_clr  = dip_good ? mask : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_HUNT;
         slot    <= '0;
         acc     <= '0;
         mask    <= '0;
         dip_err <= 1'b0;
      end else begin
         dip_err <= dip_bad;
         unique case (state)
            ST_HUNT: if (is_frame) begin
               state <= ST_SLOT;
               slot  <= '0;
               acc   <= '0;
               mask  <= '0;
            end
            ST_SLOT: if (is_frame) begin
               slot <= '0;
               acc  <= '0;
               mask <= '0;
            end else begin
               acc  <= acc ^ stat_word;
               mask <= mask | chan_hot;
               if (slot == cal_len) state <= ST_DIP;
               else                 slot  <= slot + 1'b1;
            end
            default: state <= ST_HUNT;
         endcase
      end
   end

   fsr_stat_mem #(.NCH(NCH), .RD_REG(RD_REG)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(slot_chan), .wdata(stat_word),
      .sus_set(sus_set), .sus_clr(sus_clr), .rd_addr(rd_addr), .rd_data(rd_data));

   fsr_sync_mon #(.GOOD_N(GOOD_N), .BAD_N(BAD_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .good_evt(dip_good), .bad_evt(dip_bad || abort),
      .sync(link_sync));

   AST_DIP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      dip_err |=> !dip_err); // R4
   AST_FRAME_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HUNT && stat_word == FRAME_WORD) |=> (state == ST_SLOT && slot == '0)); // R2
   AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SLOT && stat_word == FRAME_WORD) |=> (state == ST_SLOT && slot == '0)); // R6
   AST_HUNT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HUNT && stat_word != FRAME_WORD) |=> state == ST_HUNT); // R10
   AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SLOT) |-> slot <= cal_len); // R1
endmodule

// File: tb/fifo_stat_rx_tb.sv
module fifo_stat_rx_tb;
   localparam int PERIOD = 10;
   localparam int NCH    = 8;
   localparam int CH_W   = 3;
   localparam int CA_W   = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cal_we = 1'b0;
   logic [CA_W-1:0] cal_addr = '0;
   logic [CH_W-1:0] cal_chan = '0;
   logic            len_we = 1'b0;
   logic [CA_W-1:0] len_val = '0;
   logic [1:0]      stat_word = 2'b00;
   logic [CH_W-1:0] rd_addr = '0;
   logic [2:0]      rd_data;
   logic            dip_err, link_sync;

   int checks = 0;
   int errors = 0;
   logic [2:0] exp_q [$];
   string      tag_q [$];

   always #(PERIOD/2) clk = ~clk;

   fifo_stat_rx u_dut (
      .clk(clk), .rst_n(rst_n), .cal_we(cal_we), .cal_addr(cal_addr),
      .cal_chan(cal_chan), .len_we(len_we), .len_val(len_val),
      .stat_word(stat_word), .rd_addr(rd_addr), .rd_data(rd_data),
      .dip_err(dip_err), .link_sync(link_sync));

   // monitor: consumes one queued read per clock, one cycle after the request
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [2:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (rd_data !== e) begin
            errors++;
            $display("FAIL %s: rd_data actual %b expected %b", t, rd_data, e);
         end
      end
   end

   task automatic check_rd(input int ch, input logic [2:0] e, input string t);
      @(negedge clk);
      rd_addr = CH_W'(ch);
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic drain();
      while (exp_q.size() > 0) @(posedge clk);
      @(posedge clk); #1;
   endtask

   task automatic check_bit(input logic act, input logic e, input string t);
      checks++;
      if (act !== e) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", t, act, e);
      end
   endtask

   task automatic prog(input int a, input int ch);
      @(negedge clk);
      cal_we = 1'b1; cal_addr = CA_W'(a); cal_chan = CH_W'(ch);
      @(negedge clk);
      cal_we = 1'b0;
   endtask

   task automatic set_len(input int l);
      @(negedge clk);
      len_we = 1'b1; len_val = CA_W'(l);
      @(negedge clk);
      len_we = 1'b0;
   endtask

   task automatic send_word(input logic [1:0] w);
      @(negedge clk);
      stat_word = w;
      @(posedge clk); #1;
      stat_word = 2'b00;
   endtask

   // sends slot words and a parity word; returns after the parity edge
   task automatic send_slots(input logic [1:0] ws [8], input int n, input bit good);
      logic [1:0] x;
      x = 2'b00;
      for (int i = 0; i < n; i++) begin
         send_word(ws[i]);
         x = x ^ ws[i];
      end
      send_word(good ? ~x : (~x ^ 2'b01));
   endtask

   initial begin
      #(PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [1:0] ws [8];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R9 reset state
      check_bit(link_sync, 1'b0, "R9 link_sync after reset");
      check_bit(dip_err, 1'b0, "R9 dip_err after reset");
      check_rd(0, 3'b000, "R9 ch0 reset");
      check_rd(7, 3'b000, "R9 ch7 reset");
      drain();

      // R1 program calendar 0..3, length 4 slots
      for (int i = 0; i < 4; i++) prog(i, i);
      set_len(3);

      // R10 junk while hunting
      send_word(2'b01); send_word(2'b10); send_word(2'b01);
      check_rd(1, 3'b000, "R10 ch1 untouched while hunting");
      check_rd(0, 3'b000, "R10 ch0 untouched while hunting");
      drain();

      // R2/R7 first good cycle
      ws = '{2'b01, 2'b10, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00};
      send_word(2'b11);
      send_slots(ws, 4, 1'b1);
      check_bit(dip_err, 1'b0, "R4 no error on good parity");
      check_bit(link_sync, 1'b0, "R8 not synced after one good cycle");
      check_rd(0, 3'b001, "R2 ch0 slot0");
      check_rd(1, 3'b010, "R2 ch1 slot1");
      check_rd(2, 3'b000, "R2 ch2 slot2");
      check_rd(3, 3'b001, "R7 ch3 slot3");
      drain();

      // R8 second good cycle locks
      send_word(2'b11);
      send_slots(ws, 4, 1'b1);
      check_bit(link_sync, 1'b1, "R8 synced after two good cycles");

      // R3 repeating calendar 5,6,5,7,5 with 5 slots
      prog(0, 5); prog(1, 6); prog(2, 5); prog(3, 7); prog(4, 5);
      set_len(4);
      ws = '{2'b10, 2'b01, 2'b00, 2'b01, 2'b01, 2'b00, 2'b00, 2'b00};
      send_word(2'b11);
      send_slots(ws, 5, 1'b1);
      check_rd(5, 3'b001, "R3 ch5 last occurrence wins");
      check_rd(6, 3'b001, "R3 ch6");
      check_rd(7, 3'b001, "R1 ch7 at entry 3");
      drain();

      // R4/R5 bad parity cycle
      ws = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00};
      send_word(2'b11);
      send_slots(ws, 5, 1'b0);
      check_bit(dip_err, 1'b1, "R4 dip_err on mismatch");
      check_bit(link_sync, 1'b1, "R8 still synced after one bad cycle");
      @(posedge clk); #1;
      check_bit(dip_err, 1'b0, "R4 dip_err one cycle only");
      check_rd(5, 3'b100, "R5 ch5 suspect");
      check_rd(7, 3'b100, "R5 ch7 suspect");
      check_rd(0, 3'b001, "R5 ch0 not written stays clean");
      drain();

      // R8 second bad drops sync
      send_word(2'b11);
      send_slots(ws, 5, 1'b0);
      check_bit(link_sync, 1'b0, "R8 sync lost after two bad cycles");

      // R5 good cycle clears suspect
      ws = '{2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b00, 2'b00, 2'b00};
      send_word(2'b11);
      send_slots(ws, 5, 1'b1);
      check_rd(5, 3'b001, "R5 ch5 suspect cleared");
      check_rd(6, 3'b001, "R5 ch6 suspect cleared");
      drain();

      // R6 framing word inside a cycle restarts at slot 0
      send_word(2'b11);
      send_word(2'b10);
      send_word(2'b11);
      ws = '{2'b01, 2'b10, 2'b01, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00};
      send_slots(ws, 5, 1'b1);
      check_bit(dip_err, 1'b0, "R6 parity good after resync");
      check_bit(link_sync, 1'b0, "R8 abort counted as bad");
      check_rd(5, 3'b000, "R6 ch5 after resync");
      check_rd(6, 3'b010, "R6 ch6 after resync");
      check_rd(7, 3'b010, "R6 ch7 slot3 after resync");
      drain();

      // R8 one more good cycle relocks
      ws = '{2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b00, 2'b00, 2'b00};
      send_word(2'b11);
      send_slots(ws, 5, 1'b1);
      check_bit(link_sync, 1'b1, "R8 relocked");
      check_rd(5, 3'b010, "R2 ch5 final");
      drain();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule